// File: doc/BRIEF.md
# Card Command and Response Sequencer

This block starts one command on a memory card and collects the card's reply. Software loads a 6-bit command index, a 32-bit argument written as two 16-bit halves, and a control word that selects the expected response type and whether a data phase follows. The command goes out over a valid/ready request channel to a card-side interface once the card clock is running. That interface answers with up to 16 response bytes and a byte count.

The reply is judged against the programmed response type. A reply that is long enough is packed into a nine-entry halfword response queue, and the end-of-response status flag is set. A reply that is too short sets the response-timeout flag instead. Software drains the queue one halfword per read. When the control word requests a data phase, the remaining transfer byte count is loaded from block count times block length. A clock-stop command drops the clock-enable flag and aborts whatever is in progress.

Top module: `mmc_cmd_seq`

Register addresses (`reg_addr`): 0 clock control (write bit 0 = start, bit 1 = stop), 1 status, 2 command index, 3 argument upper half, 4 argument lower half, 5 control word, 6 block length, 7 block count, 8 response queue pop, 9 end-of-command request (write bit 0 = 1 clears it). Reads of any other address return 0.

## Requirements
- R1: The command index keeps the low 6 bits written to address 2. Reading address 2 returns the index with bit 6 set, and `card_cmd` presents the index.
- R2: A write to address 3 replaces only bits 31:16 of the argument. A write to address 4 replaces only bits 15:0. `card_arg` presents the full 32-bit argument.
- R3: The control word stores the written value ANDed with 0x3DFF and reads back that value. Its fields are: response type in bits 1:0, data enable in bit 2, write/read in bit 3, DMA enable in bit 7 and stop-transfer in bit 10.
- R4: Writing the control word marks a command pending. If the clock is enabled and the written stop-transfer bit is 0, `card_req_valid` rises on the next cycle and stays high until `card_req_ready` is seen.
- R5: A pending command written while the clock is off is issued by the next clock-start write, unless stop-transfer is set in the stored control word. In that case no request is made.
- R6: Response type 0 always succeeds. Types 1 and 3 need `card_rsp_len` >= 4, and type 2 needs `card_rsp_len` >= 16. A shorter reply sets status bit 1 (response timeout) and ends the operation.
- R7: Every reply received raises `end_cmd_req`, which stays high until software writes 1 to bit 0 of address 9.
- R8: On success, status bit 13 is set. Queue entry i holds response byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Bytes at or past `card_rsp_len` read as 0.
- R9: The response queue holds 9 halfwords. Each read of address 8 returns the next entry. After all nine have been read, reads return 0.
- R10: On success with data enable set, `bytes_left` loads block length (12 bits) times block count (16 bits) and `xfer_active` stays high. Otherwise `xfer_active` falls when the reply is received.
- R11: A clock-stop write clears status bit 8 (clock enabled), drops `xfer_active` and withdraws any outstanding card request.
- R12: Issuing a command clears every status bit except bit 8, so the status after a reply shows exactly one of bits 1 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the response queue at address 8) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on address |
| card_req_valid | output | 1 | Command request valid |
| card_req_ready | input | 1 | Card interface accepts the request |
| card_cmd | output | 6 | Command index for the card |
| card_arg | output | 32 | Command argument for the card |
| card_rsp_valid | input | 1 | Reply present, one-cycle pulse |
| card_rsp_len | input | 5 | Number of valid reply bytes |
| card_rsp_data | input | 128 | Reply bytes, byte 0 in bits 7:0 |
| end_cmd_req | output | 1 | End-of-command request |
| xfer_active | output | 1 | Operation in progress |
| bytes_left | output | 28 | Data-phase byte count |

## Verification
The embedded properties check the following on every cycle: that a request stays up until it is accepted, that a clock stop always leaves the clock flag, the request and the active flag low, that timeout and end-of-response are never set together, that the queue read pointer stays in range, and that the end-of-command request only rises after a reply. How a reply is judged, the halfword packing, zero fill of unused entries, the byte-count product and deferred issue on clock start depend on specific data and register sequences. Only the bench scenarios show those, by comparing randomised replies against expected values it computes itself.

// File: rtl/mmc_cmd_seq.sv
module mmc_cmd_seq #(
  parameter int RESP_HW   = 9,
  parameter int RSP_BYTES = 16,
  parameter int LONG_RSP  = 16,
  parameter int SHORT_RSP = 4,
  parameter int BLKLEN_W  = 12,
  parameter int BLKCNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [3:0]                 reg_addr,
  input  logic [15:0]                reg_wdata,
  output logic [15:0]                reg_rdata,
  output logic                       card_req_valid,
  input  logic                       card_req_ready,
  output logic [5:0]                 card_cmd,
  output logic [31:0]                card_arg,
  input  logic                       card_rsp_valid,
  input  logic [4:0]                 card_rsp_len,
  input  logic [8*RSP_BYTES-1:0]     card_rsp_data,
  output logic                       end_cmd_req,
  output logic                       xfer_active,
  output logic [BLKLEN_W+BLKCNT_W-1:0] bytes_left
);
  localparam int PTR_W = $clog2(RESP_HW + 1);
  localparam int CNT_W = BLKLEN_W + BLKCNT_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [5:0]          cmd_q;
  logic [31:0]         arg_q;
  logic [13:0]         ctl_q;
  logic [BLKLEN_W-1:0] blen_q;
  logic [BLKCNT_W-1:0] bcnt_q;
  logic                clk_on, tout, rsp_end, pending;
  logic [15:0]         rq [RESP_HW];
  logic [PTR_W-1:0]    rptr;

  wire wr_clk  = reg_wr && reg_addr == 4'd0;
  wire wr_ctl  = reg_wr && reg_addr == 4'd5;
  wire pop     = reg_rd && reg_addr == 4'd8 && rptr < PTR_W'(RESP_HW);
  wire stop    = wr_clk && reg_wdata[1];
  wire start_go = wr_clk && reg_wdata[0] && !reg_wdata[1] && pending && !ctl_q[10];
  wire ctl_go  = wr_ctl && !reg_wdata[10] && clk_on;
  wire go      = ctl_go || start_go;
  wire got_rsp = st == S_WAIT && card_rsp_valid;
  wire rsp_ok  = ctl_q[1:0] == 2'd0 ||
                 (ctl_q[1:0] == 2'd2 ? 32'(card_rsp_len) >= LONG_RSP
                                     : 32'(card_rsp_len) >= SHORT_RSP);

  assign card_req_valid = st == S_REQ;
  assign card_cmd = cmd_q;
  assign card_arg = arg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd_q <= '0; arg_q <= '0; ctl_q <= '0; blen_q <= '0; bcnt_q <= '0;
      clk_on <= 1'b0; tout <= 1'b0; rsp_end <= 1'b0; pending <= 1'b0;
      rptr <= PTR_W'(RESP_HW); end_cmd_req <= 1'b0; xfer_active <= 1'b0; bytes_left <= '0;
      for (int i = 0; i < RESP_HW; i++) rq[i] <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          4'd2: cmd_q <= reg_wdata[5:0];
          4'd3: arg_q[31:16] <= reg_wdata;
          4'd4: arg_q[15:0] <= reg_wdata;
          4'd6: blen_q <= reg_wdata[BLKLEN_W-1:0];
          4'd7: bcnt_q <= reg_wdata[BLKCNT_W-1:0];
          4'd9: if (reg_wdata[0]) end_cmd_req <= 1'b0;
          default: ;
        endcase
      end
      if (pop) rptr <= rptr + 1'b1;
      if (st == S_REQ && card_req_ready) st <= S_WAIT;
      if (got_rsp) begin
        st <= S_IDLE;
        end_cmd_req <= 1'b1;
        rptr <= '0;
        for (int i = 0; i < RESP_HW; i++)
          for (int b = 0; b < 2; b++)
            rq[i][8*b +: 8] <= (rsp_ok && 2*i+b < RSP_BYTES && 2*i+b < 32'(card_rsp_len))
                               ? card_rsp_data[8*((2*i+b) % RSP_BYTES) +: 8] : 8'h00;
        if (rsp_ok) begin
          rsp_end <= 1'b1;
          if (ctl_q[2]) bytes_left <= CNT_W'(blen_q) * CNT_W'(bcnt_q);
          else xfer_active <= 1'b0;
        end else begin
          tout <= 1'b1;
          xfer_active <= 1'b0;
        end
      end
      if (wr_ctl) begin
        ctl_q <= reg_wdata[13:0] & 14'h3DFF;
        pending <= 1'b1;
        xfer_active <= 1'b0;
        if (!reg_wdata[10]) begin tout <= 1'b0; rsp_end <= 1'b0; end
      end
      if (wr_clk && reg_wdata[0]) clk_on <= 1'b1;
      if (go) begin
        st <= S_REQ; pending <= 1'b0; xfer_active <= 1'b1;
        tout <= 1'b0; rsp_end <= 1'b0;
      end
      if (stop) begin
        clk_on <= 1'b0; xfer_active <= 1'b0; st <= S_IDLE;
      end
    end
  end

  wire [15:0] status = {2'b00, rsp_end, 4'b0000, clk_on, 6'b000000, tout, 1'b0};

  always_comb begin
    case (reg_addr)
      4'd1: reg_rdata = status;
      4'd2: reg_rdata = {9'd0, 1'b1, cmd_q};
      4'd3: reg_rdata = arg_q[31:16];
      4'd4: reg_rdata = arg_q[15:0];
      4'd5: reg_rdata = {2'b00, ctl_q};
      4'd6: reg_rdata = 16'(blen_q);
      4'd7: reg_rdata = 16'(bcnt_q);
      4'd8: reg_rdata = (rptr < PTR_W'(RESP_HW)) ? rq[rptr] : 16'h0000;
      4'd9: reg_rdata = {15'd0, end_cmd_req};
      default: reg_rdata = 16'h0000;
    endcase
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    card_req_valid && !card_req_ready && !stop |=> card_req_valid);
  p_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> card_req_valid && xfer_active);
  p_status_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(tout && rsp_end));
  p_ptr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rptr <= PTR_W'(RESP_HW));
  p_end_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_cmd_req) |-> $past(card_rsp_valid));
  p_clk_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !clk_on && !xfer_active && !card_req_valid);
endmodule

// File: tb/test_mmc_cmd_seq.sv
module test_mmc_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, card_req_ready = 0, card_rsp_valid = 0;
  logic [3:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic card_req_valid, end_cmd_req, xfer_active;
  logic [5:0] card_cmd;
  logic [31:0] card_arg;
  logic [4:0] card_rsp_len = 0;
  logic [127:0] card_rsp_data = 0;
  logic [27:0] bytes_left;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mmc_cmd_seq i_mmc_cmd_seq (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  function automatic logic exp_ok(input logic [1:0] t, input int len);
    if (t == 0) return 1'b1;
    if (t == 2) return len >= 16;
    return len >= 4;
  endfunction

  function automatic logic [15:0] exp_hw(input logic [127:0] d, input int len, input int i, input logic ok);
    logic [15:0] h = 0;
    for (int b = 0; b < 2; b++)
      if (ok && 2*i+b < 16 && 2*i+b < len) h[8*b +: 8] = d[8*(2*i+b) +: 8];
    return h;
  endfunction

  task automatic answer(input int len, input logic [127:0] d);
    card_req_ready = 1; @(negedge clk); card_req_ready = 0;
    card_rsp_valid = 1; card_rsp_len = 5'(len); card_rsp_data = d;
    @(negedge clk); card_rsp_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [127:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd(4'd1, v); chk("R12 reset status", v, 0);
    chk("R4 reset no request", card_req_valid, 0);
    chk("R7 reset end request", end_cmd_req, 0);
    rd(4'd8, v); chk("R9 reset queue empty", v, 0);

    wr(4'd2, 16'hFFFF); rd(4'd2, v); chk("R1 index readback", v, 16'h007F);
    chk("R1 card_cmd", card_cmd, 6'h3F);
    wr(4'd3, 16'h1234); wr(4'd4, 16'hABCD); chk("R2 full arg", card_arg, 32'h1234ABCD);
    wr(4'd3, 16'h5555); chk("R2 high only", card_arg, 32'h5555ABCD);
    wr(4'd4, 16'h0F0F); chk("R2 low only", card_arg, 32'h55550F0F);

    wr(4'd5, 16'hFFFF); rd(4'd5, v); chk("R3 masked control", v, 16'h3DFF);
    wr(4'd0, 16'h0001); chk("R5 stop-transfer blocks start", card_req_valid, 0);
    rd(4'd1, v); chk("R11 clock flag set", v, 16'h0100);
    wr(4'd0, 16'h0002); rd(4'd1, v); chk("R11 clock flag cleared", v, 16'h0000);

    wr(4'd5, 16'h0001); repeat (3) @(negedge clk);
    chk("R5 no issue while clock off", card_req_valid, 0);
    wr(4'd0, 16'h0001); chk("R5 issued by clock start", card_req_valid, 1);
    repeat (2) @(negedge clk); chk("R4 request held", card_req_valid, 1);
    answer(6, 128'h0000_0000_0000_0000_0000_0605_0403_0201);
    rd(4'd1, v); chk("R8 end-of-response status", v, 16'h2100);
    rd(4'd8, v); chk("R8 first halfword", v, 16'h0201);

    wr(4'd5, 16'h0001); chk("R4 immediate issue", card_req_valid, 1);
    chk("R10 active during command", xfer_active, 1);
    wr(4'd0, 16'h0002);
    chk("R11 request withdrawn", card_req_valid, 0);
    chk("R11 active dropped", xfer_active, 0);
    rd(4'd1, v); chk("R11 clock flag after abort", v[8], 0);
    wr(4'd0, 16'h0001);

    for (int it = 0; it < 60; it++) begin
      logic [1:0] t = 2'($urandom_range(0, 3));
      int len = $urandom_range(0, 16);
      logic den = 1'($urandom);
      logic [11:0] bl = 12'($urandom);
      logic [15:0] bc = 16'($urandom);
      logic ok;
      if (it == 0) begin t = 2; len = 15; end
      if (it == 1) begin t = 2; len = 16; end
      if (it == 2) begin t = 3; len = 3; end
      if (it == 3) begin t = 1; len = 4; den = 1; bl = 12'hFFF; bc = 16'hFFFF; end
      ok = exp_ok(t, len);
      d = {$urandom, $urandom, $urandom, $urandom};
      wr(4'd6, 16'(bl)); wr(4'd7, bc);
      wr(4'd9, 16'h0001);
      wr(4'd5, {13'd0, den, t});
      chk("R4 request raised", card_req_valid, 1);
      answer(len, d);
      chk("R7 end-of-command request", end_cmd_req, 1);
      rd(4'd1, v); chk("R6 R8 R12 status", v, ok ? 16'h2100 : 16'h0102);
      chk("R10 active", xfer_active, ok && den);
      if (ok && den) chk("R10 byte count", bytes_left, 28'(bl) * 28'(bc));
      for (int i = 0; i < 10; i++) begin
        rd(4'd8, v); chk(i < 9 ? "R8 queue entry" : "R9 read past end", v, i < 9 ? exp_hw(d, len, i, ok) : 16'h0);
      end
    end
    wr(4'd9, 16'h0001); chk("R7 request cleared", end_cmd_req, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule